// File: doc/BRIEF.md
# DRAM Access Cycle Sequencer

This block sits between an on-chip bus master and an external DRAM. The master presents a read or write request together with an address. When the address falls in the DRAM region and that region is enabled, the block runs an access in three parts. First it drives the row half of the address, then the column half, on one shared address output. It also produces active-low row strobe, column strobe, write enable and output enable. Requests to any other region complete as a one-state normal-space access, with a select pulse and no DRAM strobes.

A small control register shapes the cycle:
- When RAS goes active within the row state.
- Whether the column phase lasts two or three states.
- Whether the DRAM region is enabled.
- Whether fast-page bursts are allowed.

In burst mode the row stays open after an access. A request for the same row that arrives in the very next cycle skips the row state. Any other follow-on request releases the row first. Each access ends with a one-cycle done pulse, and read data is valid during that pulse.

Top module: `dram_seq`

## Requirements
- R1: After reset the control register reads 0x00. ready_o is high, done_o and norm_sel_o are low, and ras_n_o, cas_n_o, we_n_o and oe_n_o are all high.
- R2: An address is DRAM space only when addr_i[11:10] equals 2'b10 and control bit 2 is 1. Every other request runs one state with norm_sel_o high and all DRAM strobes high, followed by the done state.
- R3: Control bit 0 selects when RAS goes active in the row state. With bit 0 at 1, ras_n_o is low for the whole row state. With bit 0 at 0, it is high in the first half and low from the falling clock edge onward.
- R4: Control bit 1 sets the column phase length: 0 gives 2 states and 1 gives 3 states.
- R5: dram_addr_o carries addr_i[9:5] during precharge and row states, and addr_i[4:0] during column states.
- R6: cas_n_o is low in every column state except the first. On writes, we_n_o is low in all column states and wdata_o holds the request data. On reads, oe_n_o is low exactly when cas_n_o is low.
- R7: done_o is high for exactly the one state that follows the last column state (or the normal state), and ready_o is high in that state. rdata_o then holds the read data sampled at the edge that ended the last state.
- R8: With control bit 3 at 1, a DRAM request that is accepted in the done state and targets the open row goes straight to the column states. ras_n_o stays low throughout.
- R9: With control bit 3 at 1, a DRAM request in the done state that misses the open row first gets one precharge state with ras_n_o high, then a row state. If no request is accepted in the done state, RAS is released and a later access starts with a row state.
- R10: With control bit 3 at 0, every DRAM access starts with a row state and ras_n_o is high in the done state.
- R11: Register bits 7:4 have no function but read back the value last written.
- R12: Each access runs with the control values held when it was accepted. A register write at the accepting edge or later does not change the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write value |
| reg_rdata_o | output | 8 | Control register readback |
| req_i | input | 1 | Access request, accepted while ready_o is high |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Request address |
| wdata_i | input | DATA_W | Write data |
| ready_o | output | 1 | Sequencer idle, request may be accepted |
| done_o | output | 1 | One-cycle access completion pulse |
| rdata_o | output | DATA_W | Captured read data |
| mem_rdata_i | input | DATA_W | Data returned by memory |
| mem_wdata_o | output | DATA_W | Data driven to memory |
| dram_addr_o | output | DA_W | Multiplexed row/column address |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| oe_n_o | output | 1 | Output enable / read strobe, active low |
| norm_sel_o | output | 1 | Normal-space access select |
| norm_addr_o | output | ADDR_W | Address of the accepted request |

## Verification
The embedded properties check several rules on every cycle:
- CAS never goes low without RAS.
- A read has output enable with CAS, and write data stays steady while CAS is held.
- A normal-space select never shows DRAM strobes.
- done lasts one cycle and precharge leads into a row state.
- The held configuration does not change during the column phase, and the column counter stays within its bound.

Only the bench scenarios can show that the cycle shape follows each register setting:
- The half-cycle RAS placement.
- The two- or three-state column phase.
- The multiplexed address values.
- The choice between page hit, precharge and plain row start, depending on how the next request arrives.
- The snapshot of configuration at acceptance.

// File: rtl/dram_seq_pkg.sv
`timescale 1ns/1ps
package dram_seq_pkg;
  // bit 0 ras_early, bit 1 col3, bit 2 dram_en, bit 3 burst, 7:4 spare
  typedef struct packed {
    logic [3:0] spare;
    logic       burst;
    logic       dram_en;
    logic       col3;
    logic       ras_early;
  } ctl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NORM,
    ST_PRE,
    ST_ROW,
    ST_COL
  } st_e;
endpackage

// File: rtl/dram_seq_regs.sv
`timescale 1ns/1ps
module dram_seq_regs
  import dram_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  output logic       ras_early_o,
  output logic       col3_o,
  output logic       dram_en_o,
  output logic       burst_o
);
  ctl_t ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctl_q <= '0;
    else if (wr_en_i) ctl_q <= ctl_t'(wr_data_i);
  end

  assign rd_data_o   = ctl_q;
  assign ras_early_o = ctl_q.ras_early;
  assign col3_o      = ctl_q.col3;
  assign dram_en_o   = ctl_q.dram_en;
  assign burst_o     = ctl_q.burst;

  // R11
  spare_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/dram_seq_addr.sv
`timescale 1ns/1ps
module dram_seq_addr
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int AREA_W    = 2,
  parameter int COL_W     = 5,
  parameter int ROW_W     = 5,
  parameter int DA_W      = 5,
  parameter int DRAM_AREA = 2
) (
  input  logic [ADDR_W-1:COL_W]        req_hi_i,
  input  logic [ADDR_W-AREA_W-1:0]     acc_addr_i,
  input  logic [ROW_W-1:0]             open_row_i,
  input  st_e                          state_i,
  input  logic                         dram_en_i,
  output logic                         in_dram_o,
  output logic                         row_hit_o,
  output logic [DA_W-1:0]              dram_addr_o
);
  logic [ROW_W-1:0] acc_row;
  logic [COL_W-1:0] acc_col;

  assign in_dram_o = dram_en_i &&
                     (req_hi_i[ADDR_W-1 -: AREA_W] == AREA_W'(DRAM_AREA));
  assign row_hit_o = (req_hi_i[COL_W +: ROW_W] == open_row_i);

  assign acc_row = acc_addr_i[COL_W +: ROW_W];
  assign acc_col = acc_addr_i[COL_W-1:0];

  always_comb begin
    unique case (state_i)
      ST_PRE, ST_ROW: dram_addr_o = DA_W'(acc_row);
      ST_COL:         dram_addr_o = DA_W'(acc_col);
      default:        dram_addr_o = '0;
    endcase
  end
endmodule

// File: rtl/dram_seq_ctrl.sv
`timescale 1ns/1ps
module dram_seq_ctrl
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int COL_W  = 5,
  parameter int ROW_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              in_dram_i,
  input  logic              row_hit_i,
  input  logic              cfg_ras_early_i,
  input  logic              cfg_col3_i,
  input  logic              cfg_burst_i,
  output st_e               state_o,
  output logic [1:0]        col_cnt_o,
  output logic              ras_early_o,
  output logic              open_o,
  output logic              write_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [ROW_W-1:0]  open_row_o,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  st_e               state_q;
  logic [1:0]        col_cnt_q, col_last;
  logic              ras_early_q, col3_q, burst_q;
  logic              open_q, write_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [ROW_W-1:0]  open_row_q;

  assign col_last = col3_q ? 2'd2 : 2'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      col_cnt_q   <= '0;
      ras_early_q <= 1'b0;
      col3_q      <= 1'b0;
      burst_q     <= 1'b0;
      open_q      <= 1'b0;
      write_q     <= 1'b0;
      done_q      <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      rdata_q     <= '0;
      open_row_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          open_q <= 1'b0; // page survives only the done state
          if (req_i) begin
            addr_q      <= addr_i;
            write_q     <= we_i;
            wdata_q     <= wdata_i;
            ras_early_q <= cfg_ras_early_i;
            col3_q      <= cfg_col3_i;
            burst_q     <= cfg_burst_i;
            col_cnt_q   <= '0;
            if (!in_dram_i)                            state_q <= ST_NORM;
            else if (open_q && cfg_burst_i && row_hit_i) state_q <= ST_COL;
            else if (open_q)                           state_q <= ST_PRE;
            else                                       state_q <= ST_ROW;
          end
        end
        ST_NORM: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          if (!write_q) rdata_q <= mem_rdata_i;
        end
        ST_PRE: state_q <= ST_ROW;
        ST_ROW: begin
          state_q   <= ST_COL;
          col_cnt_q <= '0;
        end
        ST_COL: begin
          if (col_cnt_q == col_last) begin
            state_q    <= ST_IDLE;
            done_q     <= 1'b1;
            open_q     <= burst_q;
            open_row_q <= addr_q[COL_W +: ROW_W];
            if (!write_q) rdata_q <= mem_rdata_i;
          end else begin
            col_cnt_q <= col_cnt_q + 2'd1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o     = state_q;
  assign col_cnt_o   = col_cnt_q;
  assign ras_early_o = ras_early_q;
  assign open_o      = open_q;
  assign write_o     = write_q;
  assign addr_o      = addr_q;
  assign wdata_o     = wdata_q;
  assign open_row_o  = open_row_q;
  assign ready_o     = (state_q == ST_IDLE);
  assign done_o      = done_q;
  assign rdata_o     = rdata_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R12
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COL && $past(state_q) == ST_COL) |->
      ($stable(col3_q) && $stable(burst_q) && $stable(ras_early_q)));
  // R4
  col_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COL) |-> (col_cnt_q <= (col3_q ? 2'd2 : 2'd1)));
  // R9
  pre_to_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PRE) |=> (state_q == ST_ROW));
endmodule

// File: rtl/dram_seq_strobe.sv
`timescale 1ns/1ps
module dram_seq_strobe
  import dram_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  st_e               state_i,
  input  logic [1:0]        col_cnt_i,
  input  logic              ras_early_i,
  input  logic              open_i,
  input  logic              write_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic              oe_n_o,
  output logic              norm_sel_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  logic half_q, col_act, cas_on, ras_on;

  // late RAS: captured on the falling edge inside the row state
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) half_q <= 1'b0;
    else         half_q <= (state_i == ST_ROW);
  end

  assign col_act = (state_i == ST_COL);
  assign cas_on  = col_act && (col_cnt_i != 2'd0);
  assign ras_on  = ((state_i == ST_ROW) && ras_early_i) || col_act ||
                   ((state_i == ST_IDLE) && open_i);

  assign ras_n_o     = !(ras_on || half_q);
  assign cas_n_o     = !cas_on;
  assign we_n_o      = !(col_act && write_i);
  assign oe_n_o      = !(cas_on && !write_i);
  assign norm_sel_o  = (state_i == ST_NORM);
  assign mem_wdata_o = wdata_i;

  // R6
  cas_needs_ras_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_n_o |-> !ras_n_o);
  // R6
  read_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cas_n_o && we_n_o) |-> !oe_n_o);
  // R6
  wdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cas_n_o && !we_n_o && $past(!cas_n_o)) |-> $stable(mem_wdata_o));
  // R2
  norm_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    norm_sel_o |-> (ras_n_o && cas_n_o && we_n_o && oe_n_o));
endmodule

// File: rtl/dram_seq.sv
`timescale 1ns/1ps
module dram_seq
  import dram_seq_pkg::*;
#(
  parameter  int ADDR_W    = 12,
  parameter  int DATA_W    = 8,
  parameter  int AREA_W    = 2,
  parameter  int COL_W     = 5,
  parameter  int DRAM_AREA = 2,
  localparam int ROW_W     = ADDR_W - AREA_W - COL_W,
  localparam int DA_W      = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [DA_W-1:0]   dram_addr_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic              oe_n_o,
  output logic              norm_sel_o,
  output logic [ADDR_W-1:0] norm_addr_o
);
  logic              c_ras_early, c_col3, c_dram_en, c_burst;
  logic              in_dram, row_hit, act_ras_early, open_pg, write_q;
  st_e               state;
  logic [1:0]        col_cnt;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] acc_wdata;
  logic [ROW_W-1:0]  open_row;

  dram_seq_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (reg_we_i),
    .wr_data_i   (reg_wdata_i),
    .rd_data_o   (reg_rdata_o),
    .ras_early_o (c_ras_early),
    .col3_o      (c_col3),
    .dram_en_o   (c_dram_en),
    .burst_o     (c_burst)
  );

  dram_seq_addr #(
    .ADDR_W(ADDR_W), .AREA_W(AREA_W), .COL_W(COL_W), .ROW_W(ROW_W),
    .DA_W(DA_W), .DRAM_AREA(DRAM_AREA)
  ) u_addr (
    .req_hi_i    (addr_i[ADDR_W-1:COL_W]),
    .acc_addr_i  (acc_addr[ADDR_W-AREA_W-1:0]),
    .open_row_i  (open_row),
    .state_i     (state),
    .dram_en_i   (c_dram_en),
    .in_dram_o   (in_dram),
    .row_hit_o   (row_hit),
    .dram_addr_o (dram_addr_o)
  );

  dram_seq_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W), .ROW_W(ROW_W)
  ) u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_i           (req_i),
    .we_i            (we_i),
    .addr_i          (addr_i),
    .wdata_i         (wdata_i),
    .mem_rdata_i     (mem_rdata_i),
    .in_dram_i       (in_dram),
    .row_hit_i       (row_hit),
    .cfg_ras_early_i (c_ras_early),
    .cfg_col3_i      (c_col3),
    .cfg_burst_i     (c_burst),
    .state_o         (state),
    .col_cnt_o       (col_cnt),
    .ras_early_o     (act_ras_early),
    .open_o          (open_pg),
    .write_o         (write_q),
    .addr_o          (acc_addr),
    .wdata_o         (acc_wdata),
    .open_row_o      (open_row),
    .ready_o         (ready_o),
    .done_o          (done_o),
    .rdata_o         (rdata_o)
  );

  dram_seq_strobe #(.DATA_W(DATA_W)) u_strobe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (state),
    .col_cnt_i   (col_cnt),
    .ras_early_i (act_ras_early),
    .open_i      (open_pg),
    .write_i     (write_q),
    .wdata_i     (acc_wdata),
    .ras_n_o     (ras_n_o),
    .cas_n_o     (cas_n_o),
    .we_n_o      (we_n_o),
    .oe_n_o      (oe_n_o),
    .norm_sel_o  (norm_sel_o),
    .mem_wdata_o (mem_wdata_o)
  );

  assign norm_addr_o = acc_addr;
endmodule

// File: tb/dram_seq_tb.sv
`timescale 1ns/1ps
module dram_seq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        ready_o, done_o;
  logic [7:0]  rdata_o;
  logic [7:0]  mem_rdata_i = '0;
  logic [7:0]  mem_wdata_o;
  logic [4:0]  dram_addr_o;
  logic        ras_n_o, cas_n_o, we_n_o, oe_n_o, norm_sel_o;
  logic [11:0] norm_addr_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] cur_cfg = '0;

  always #5 clk_i = ~clk_i;

  dram_seq u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .ready_o(ready_o), .done_o(done_o), .rdata_o(rdata_o),
    .mem_rdata_i(mem_rdata_i), .mem_wdata_o(mem_wdata_o), .dram_addr_o(dram_addr_o),
    .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o), .oe_n_o(oe_n_o),
    .norm_sel_o(norm_sel_o), .norm_addr_o(norm_addr_o)
  );

  task automatic chk(input string rq, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", rq, what, act, exp, $time);
    end
  endtask

  task automatic wr_reg(input logic [7:0] v);
    reg_we_i = 1'b1; reg_wdata_i = v;
    @(posedge clk_i); #1;
    reg_we_i = 1'b0;
    cur_cfg = v;
  endtask

  // ph: 0 precharge, 1 row, 2 column
  task automatic run_acc(input logic [11:0] a, input logic w, input logic [7:0] wd,
                         input int pre, input bit hit, input bit nm, input string tag);
    int ncol, total, ph, k;
    logic [7:0] cfg;
    cfg = cur_cfg;
    ncol = cfg[1] ? 3 : 2;
    addr_i = a; we_i = w; wdata_i = wd; mem_rdata_i = a[7:0] ^ 8'hA5; req_i = 1'b1;
    @(posedge clk_i); #1;
    req_i = 1'b0; reg_we_i = 1'b0;
    if (nm) begin
      #1;
      chk({"R2 ", tag}, "norm_sel", norm_sel_o, 1);
      chk({"R2 ", tag}, "ras_n", ras_n_o, 1);
      chk({"R2 ", tag}, "cas_n", cas_n_o, 1);
      chk({"R2 ", tag}, "norm_addr", norm_addr_o, a);
      @(posedge clk_i); #1;
    end else begin
      total = hit ? ncol : pre + 1 + ncol;
      for (int i = 0; i < total; i++) begin
        if (hit)          begin ph = 2; k = i; end
        else if (i < pre) begin ph = 0; k = 0; end
        else if (i == pre) begin ph = 1; k = 0; end
        else              begin ph = 2; k = i - pre - 1; end
        #1;
        chk({"R3 ", tag}, "ras_n early", ras_n_o,
            (ph == 0) ? 1 : (ph == 1) ? (cfg[0] ? 0 : 1) : 0);
        chk({"R6 ", tag}, "cas_n", cas_n_o, (ph == 2 && k >= 1) ? 0 : 1);
        chk({"R6 ", tag}, "we_n", we_n_o, (ph == 2 && w) ? 0 : 1);
        chk({"R6 ", tag}, "oe_n", oe_n_o, (ph == 2 && !w && k >= 1) ? 0 : 1);
        chk({"R5 ", tag}, "dram_addr", dram_addr_o, (ph == 2) ? a[4:0] : a[9:5]);
        chk({"R7 ", tag}, "ready low", ready_o, 0);
        if (ph == 2 && w) chk({"R6 ", tag}, "wdata", mem_wdata_o, wd);
        #5;
        chk({"R3 ", tag}, "ras_n late", ras_n_o, (ph == 0) ? 1 : 0);
        @(posedge clk_i); #1;
      end
    end
    #1;
    chk({"R7 R4 ", tag}, "done", done_o, 1);
    chk({"R7 ", tag}, "ready", ready_o, 1);
    if (!w) chk({"R7 ", tag}, "rdata", rdata_o, a[7:0] ^ 8'hA5);
    chk({"R10 R8 ", tag}, "ras_n done", ras_n_o, (!nm && cfg[3]) ? 0 : 1);
    chk({"R6 ", tag}, "cas_n done", cas_n_o, 1);
    #5;
  endtask

  task automatic gap(input string tag);
    @(posedge clk_i); #2;
    chk({"R7 ", tag}, "done dropped", done_o, 0);
    chk({"R9 ", tag}, "page closed", ras_n_o, 1);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #3;
    // R1
    chk("R1", "reg", reg_rdata_o, 0);
    chk("R1", "ready", ready_o, 1);
    chk("R1", "done", done_o, 0);
    chk("R1", "norm_sel", norm_sel_o, 0);
    chk("R1", "strobes", {ras_n_o, cas_n_o, we_n_o, oe_n_o}, 4'hF);
    #19 rst_ni = 1'b1;
    @(posedge clk_i); #1;

    // R11
    wr_reg(8'hA0);
    chk("R11", "readback", reg_rdata_o, 8'hA0);
    wr_reg(8'h5F);
    chk("R11", "readback", reg_rdata_o, 8'h5F);

    // sweep ras timing, column length, burst
    for (int c = 0; c < 8; c++) begin
      logic [7:0] cfg;
      logic [4:0] r;
      cfg = {4'h0, c[2], 1'b1, c[1], c[0]};
      r = 5'(c + 1);
      wr_reg(cfg);
      gap("R9 setup");
      run_acc({2'b10, r, 5'd5}, 1'b1, 8'(c * 17 + 3), 0, 0, 0, "first write");
      run_acc({2'b10, r, 5'd9}, 1'b0, 8'h00, 0, c[2], 0, "R8 same row");
      run_acc({2'b10, r ^ 5'h10, 5'd30}, 1'b0, 8'h00, c[2] ? 1 : 0, 0, 0, "R9 other row");
      gap("R10 after");
      run_acc({2'b10, r ^ 5'h10, 5'd1}, 1'b0, 8'h00, 0, 0, 0, "R9 after gap");
      gap("R9 close");
    end

    // R2: outside region, region disabled, normal after open page
    wr_reg(8'h0C);
    run_acc({2'b01, 5'd3, 5'd3}, 1'b0, 8'h00, 0, 0, 1, "other area");
    gap("R2 g1");
    run_acc({2'b10, 5'd3, 5'd3}, 1'b0, 8'h00, 0, 0, 0, "open page");
    run_acc({2'b11, 5'd3, 5'd3}, 1'b0, 8'h00, 0, 0, 1, "normal after open");
    gap("R2 g2");
    wr_reg(8'h08);
    run_acc({2'b10, 5'd4, 5'd2}, 1'b1, 8'h3C, 0, 0, 1, "region disabled");
    gap("R2 g3");

    // R12: write at accepting edge does not reach the access
    wr_reg(8'h04);
    reg_we_i = 1'b1; reg_wdata_i = 8'h07;
    run_acc({2'b10, 5'd6, 5'd6}, 1'b0, 8'h00, 0, 0, 0, "R12 snapshot");
    chk("R12", "reg updated", reg_rdata_o, 8'h07);
    cur_cfg = 8'h07;
    gap("R12 g");
    run_acc({2'b10, 5'd6, 5'd7}, 1'b0, 8'h00, 0, 0, 0, "R12 next uses new");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule